// File: doc/BRIEF.md
# Serial MAC Shift Port

This block moves a 160-bit message authentication code across a one-bit serial link. The code is five 32-bit words, named A to E. It works in one of two directions, chosen when a code is loaded.

In transmit mode it presents the loaded code on the serial output, one bit per time slot. In receive mode it collects the bits that the host supplies and compares the assembled code with the locally computed one. Both directions use the same bit order. Word E goes first, then D, C and B, and word A goes last. Each word travels least significant bit first. A host can therefore use one routine for both directions.

A controller outside the block generates the bit-slot strobe from the bus timing. The same controller decides when to load a freshly computed code and when a bus reset has occurred. The block has three states:
- `ST_IDLE`: no code has been loaded.
- `ST_SHIFT`: slots are counted.
- `ST_DONE`: all 160 slots have passed.

The state transitions are:
- IDLE→SHIFT on a load.
- SHIFT→SHIFT on a load or a bus reset. Either one restarts the count.
- SHIFT→DONE on the slot that carries the last bit.
- DONE→SHIFT on a load or a bus reset.

Top module: `mac_shift_port`

## Requirements
- R1: After reset `done` and `equal` are 0 and `sdo` is 1.
- R2: `mac_in` holds word A in bits [159:128], B in [127:96], C in [95:64], D in [63:32] and E in [31:0]. Serial bit k (k = 0..159) is therefore `mac_in[k]`: E bit 0 comes first and A bit 31 comes last.
- R3: In transmit mode (`dir_tx`=1 at load), after k slots `sdo` shows serial bit k. `sdo` changes only on a slot.
- R4: `done` rises in the cycle after the 160th slot and not after the 159th. It stays high until a load or a bus reset.
- R5: In receive mode `sdi` is sampled once on each slot and placed at serial position k, using the order of R2.
- R6: `equal` is 1 only when all 160 received bits match the loaded code. A single mismatching bit, including the first (bit 0) or the last (bit 159), gives 0.
- R7: `equal` is 0 while the count is running and whenever the block is in transmit mode.
- R8: A load latches `mac_in` and `dir_tx`, clears the bit count and clears `done`.
- R9: A bus reset after a load restarts the count at bit 0 and keeps the loaded code and direction.
- R10: Slots after `done` have no effect: `done`, `equal` and `sdo` keep their values.
- R11: `sdo` is 1 whenever the block is not transmitting (idle, receive mode, or done).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| load | input | 1 | Latch `mac_in` and `dir_tx`, then start a transfer |
| bus_reset | input | 1 | Restart the count at bit 0 |
| dir_tx | input | 1 | 1 = transmit, 0 = receive (sampled at load) |
| mac_in | input | 160 | Locally computed code {A,B,C,D,E} |
| slot | input | 1 | One-cycle bit-slot strobe |
| sdi | input | 1 | Serial data from the host |
| sdo | output | 1 | Serial data to the host |
| done | output | 1 | All 160 bits have been transferred |
| equal | output | 1 | Received code matches (receive mode, after done) |

## Verification
The hardest cases to reach are a bus reset arriving partway through a transfer and a mismatch confined to a single bit at either end of the stream.

The bench handles the bus reset by driving a partial stream of wrong bits, issuing the bus reset, and then sending the full correct code. It then checks that the count restarted at bit 0.

For the mismatch cases, table rows flip exactly one chosen bit (bit 0, bit 64 or bit 159) in an otherwise correct stream. Extra slots after `done` carry garbage to confirm that the outcome is frozen.

// File: rtl/mac_shift_pkg.sv
package mac_shift_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_SHIFT = 2'd1,
        ST_DONE  = 2'd2
    } shift_state_t;
endpackage

// File: rtl/mac_bit_counter.sv
module mac_bit_counter #(
    parameter int MAX_BITS = 160,
    localparam int CW = $clog2(MAX_BITS)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          inc,
    output logic [CW-1:0] cnt,
    output logic          last
);
    localparam logic [CW-1:0] LAST_IDX = CW'(MAX_BITS - 1);

    assign last = (cnt == LAST_IDX);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)   cnt <= '0;
        else if (clr) cnt <= '0;
        else if (inc) cnt <= last ? '0 : cnt + 1'b1;
    end

    // R2: the position never leaves the 160-bit stream
    assert_cnt_in_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= LAST_IDX);

    // R8: a clear always lands on bit 0
    assert_clear_to_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (cnt == '0));
endmodule

// File: rtl/mac_shift_fsm.sv
module mac_shift_fsm
    import mac_shift_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    input  logic bus_reset,
    input  logic slot,
    input  logic last,
    output logic clr,
    output logic inc,
    output logic shifting,
    output logic done
);
    shift_state_t state, state_nx;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:  if (load) state_nx = ST_SHIFT;
            ST_SHIFT: begin
                if (load || bus_reset)  state_nx = ST_SHIFT;
                else if (slot && last)  state_nx = ST_DONE;
            end
            ST_DONE:  if (load || bus_reset) state_nx = ST_SHIFT;
            default:  state_nx = ST_IDLE;
        endcase
    end

    always_comb begin
        clr      = load || (bus_reset && state != ST_IDLE);
        inc      = (state == ST_SHIFT) && slot && !load && !bus_reset;
        shifting = (state == ST_SHIFT);
        done     = (state == ST_DONE);
    end

    // R4: the slot carrying the last bit ends the transfer
    assert_done_after_last_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (shifting && slot && last && !load && !bus_reset) |=> done);

    // R4: done stays until load or bus reset
    assert_done_holds_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !load && !bus_reset) |=> done);

    // R9: bus reset after a load resumes shifting
    assert_bus_reset_restart_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_reset && (shifting || done)) |=> shifting);
endmodule

// File: rtl/mac_shift_port.sv
module mac_shift_port #(
    parameter int WORD_W    = 32,
    parameter int NUM_WORDS = 5,
    localparam int MAC_W    = WORD_W * NUM_WORDS,
    localparam int CW       = $clog2(MAC_W)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic             bus_reset,
    input  logic             dir_tx,
    input  logic [MAC_W-1:0] mac_in,
    input  logic             slot,
    input  logic             sdi,
    output logic             sdo,
    output logic             done,
    output logic             equal
);
    logic [MAC_W-1:0] mac_q;
    logic [MAC_W-1:0] rx_q;
    logic             tx_q;
    logic [CW-1:0]    bit_pos;
    logic             at_last, cnt_clr, cnt_inc, shifting;

    mac_bit_counter #(.MAX_BITS(MAC_W)) u_cnt (
        .clk (clk), .rst_n(rst_n), .clr(cnt_clr), .inc(cnt_inc),
        .cnt (bit_pos), .last(at_last)
    );

    mac_shift_fsm u_fsm (
        .clk (clk), .rst_n(rst_n), .load(load), .bus_reset(bus_reset),
        .slot(slot), .last(at_last), .clr(cnt_clr), .inc(cnt_inc),
        .shifting(shifting), .done(done)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mac_q <= '0;
            tx_q  <= 1'b0;
        end else if (load) begin
            mac_q <= mac_in;
            tx_q  <= dir_tx;
        end
    end

    // received bits enter at the top and move down; after 160 slots bit 0 holds the first
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                 rx_q <= '0;
        else if (cnt_inc && !tx_q)  rx_q <= {sdi, rx_q[MAC_W-1:1]};
    end

    always_comb begin
        sdo   = (shifting && tx_q) ? mac_q[bit_pos] : 1'b1;
        equal = done && !tx_q && (rx_q == mac_q);
    end

    // R7: a match is only reported once the stream is complete
    assert_equal_needs_done_R7: assert property (@(posedge clk) disable iff (!rst_n)
        equal |-> done);

    // R3: the transmitted bit moves only on a slot
    assert_sdo_steady_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (shifting && tx_q && !slot && !load && !bus_reset) |=> $stable(sdo));

    // R10: slots after completion leave the received code alone
    assert_rx_frozen_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !load && !bus_reset) |=> $stable(rx_q));

    // R8: a load always reopens the transfer
    assert_load_clears_done_R8: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> !done);
endmodule

// File: tb/mac_shift_port_tb.sv
module mac_shift_port_tb;
    localparam int MAC_W = 160;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic load = 1'b0, bus_reset = 1'b0, dir_tx = 1'b0, slot = 1'b0, sdi = 1'b0;
    logic [MAC_W-1:0] mac_in = '0;
    logic sdo, done, equal;

    int n_checks = 0;
    int n_errors = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    mac_shift_port u_dut (
        .clk(clk), .rst_n(rst_n), .load(load), .bus_reset(bus_reset),
        .dir_tx(dir_tx), .mac_in(mac_in), .slot(slot), .sdi(sdi),
        .sdo(sdo), .done(done), .equal(equal)
    );

    // {seed[41:10], dir_tx[9], flip_en[8], flip_idx[7:0]}
    localparam logic [41:0] VEC [7] = '{
        {32'h0123_4567, 1'b1, 1'b0, 8'd0},
        {32'hDEAD_BEEF, 1'b1, 1'b0, 8'd0},
        {32'h1357_9BDF, 1'b0, 1'b0, 8'd0},
        {32'h2468_ACE0, 1'b0, 1'b1, 8'd0},
        {32'h2468_ACE0, 1'b0, 1'b1, 8'd159},
        {32'hCAFE_F00D, 1'b0, 1'b1, 8'd64},
        {32'h0000_0000, 1'b0, 1'b0, 8'd0}
    };

    function automatic logic [MAC_W-1:0] make_mac(input logic [31:0] seed);
        logic [MAC_W-1:0] m;
        for (int i = 0; i < 5; i++)
            m[i*32 +: 32] = seed ^ (32'h9E37_79B9 * (i + 1)) ^ {24'h0, 8'(i)};
        return m;
    endfunction

    task automatic check(input string req, input logic act, input logic exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s: actual=%b expected=%b at %0t", req, act, exp, $time);
        end
    endtask

    task automatic do_load(input logic [MAC_W-1:0] m, input logic d);
        @(negedge clk); mac_in = m; dir_tx = d; load = 1'b1;
        @(negedge clk); load = 1'b0;
    endtask

    task automatic do_slot(input logic b);
        @(negedge clk); sdi = b; slot = 1'b1;
        @(negedge clk); slot = 1'b0;
    endtask

    task automatic do_bus_reset();
        @(negedge clk); bus_reset = 1'b1;
        @(negedge clk); bus_reset = 1'b0;
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_checks++; n_errors++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end

    initial begin : main
        logic [MAC_W-1:0] m;
        repeat (3) @(negedge clk);
        // R1 reset state
        check("R1 done", done, 1'b0);
        check("R1 equal", equal, 1'b0);
        check("R1 sdo", sdo, 1'b1);
        rst_n = 1'b1;
        // R10 slots while idle change nothing
        do_slot(1'b0);
        check("R10 idle done", done, 1'b0);
        check("R11 idle sdo", sdo, 1'b1);

        foreach (VEC[v]) begin
            logic [31:0] seed; logic d, fl; logic [7:0] fi;
            {seed, d, fl, fi} = VEC[v];
            m = make_mac(seed);
            do_load(m, d);
            check("R8 done cleared", done, 1'b0);
            for (int k = 0; k < MAC_W; k++) begin
                if (d) check("R2 R3 tx bit", sdo, m[k]);
                else   check("R11 rx sdo", sdo, 1'b1);
                check("R7 equal early", equal, 1'b0);
                if (k == MAC_W - 1) check("R4 not done at 159", done, 1'b0);
                do_slot(d ? 1'b0 : (m[k] ^ (fl && (k == int'(fi)))));
            end
            check("R4 done", done, 1'b1);
            if (d) check("R7 tx equal", equal, 1'b0);
            else   check("R5 R6 equal", equal, !fl);
            check("R11 done sdo", sdo, 1'b1);
        end

        // R10: garbage slots after done freeze the outcome (last vector matched)
        do_slot(1'b1); do_slot(1'b0); do_slot(1'b1);
        check("R10 done held", done, 1'b1);
        check("R10 equal held", equal, 1'b1);
        check("R10 sdo held", sdo, 1'b1);

        // R9: transmit, partial stream, bus reset restarts at bit 0
        m = make_mac(32'hA5A5_0F0F);
        do_load(m, 1'b1);
        for (int k = 0; k < 50; k++) do_slot(1'b0);
        check("R3 tx mid", sdo, m[50]);
        do_bus_reset();
        check("R9 tx restart", sdo, m[0]);
        check("R9 done low", done, 1'b0);
        do_slot(1'b0);
        check("R9 tx second", sdo, m[1]);

        // R9: receive, wrong partial bits, bus reset, full correct stream
        m = make_mac(32'h5A5A_F0F0);
        do_load(m, 1'b0);
        for (int k = 0; k < 80; k++) do_slot(~m[k]);
        do_bus_reset();
        for (int k = 0; k < MAC_W; k++) do_slot(m[k]);
        check("R9 rx done", done, 1'b1);
        check("R9 rx equal", equal, 1'b1);

        // R9: bus reset after done reopens with same code
        do_bus_reset();
        check("R9 reopen done", done, 1'b0);
        check("R7 reopen equal", equal, 1'b0);

        // R8: load mid-transfer restarts count with new direction
        do_load(m, 1'b1);
        for (int k = 0; k < 7; k++) do_slot(1'b0);
        do_load(m, 1'b1);
        check("R8 reload bit0", sdo, m[0]);

        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end
endmodule